// File: doc/BRIEF.md
# Serial Packet Deframer with Sync Hunt

This block takes a single-bit serial stream from a radio-to-baseband link. A new bit is offered on each cycle in which the bit enable is high. Frames can arrive at any cycle and are separated by idle stretches of unpredictable length, so the block hunts continuously for a fixed 16-bit synchronisation word. When the word is found, the next eight bits are taken as a header. The header is split into a payload-size code, a logical channel type and a clear-to-send flag.

The size code selects the payload length from a parameter table. The payload is then shifted in and released as 8-bit samples that alternate between I and Q. Every sample carries the channel type of its frame, so a consumer can reject frames of an unexpected kind. Single-cycle pulses mark the start of a frame, the end of a frame and a header with a reserved size code. When a frame ends or a header is rejected, the hunt starts again on the very next bit with no memory of earlier bits.

Top module: `iq_deframer`

## Requirements
- R1: After reset, and until a valid header has been received, `sample_valid_o`, `frame_start_o`, `frame_end_o` and `header_error_o` are low.
- R2: A frame is detected when the last 16 enabled bits, MSB first, equal the sync word (default 16'hA5F0), at any bit offset and after idle bits of any count.
- R3: The 8 enabled bits that follow the sync word form the header, first bit = bit 7: size code = bits 7:5, channel type = bits 4:1, clear-to-send = bit 0. For size codes 0 to 5, `frame_start_o` pulses for one cycle after the last header bit. From then on, `frame_type_o` and `cts_o` show that header's fields for every sample of the frame.
- R4: The payload length in bits comes from the size code: 0→32, 1→64, 2→96, 3→128, 4→256, 5→512. Exactly length/8 samples are produced.
- R5: Each sample is 8 consecutive payload bits, MSB first. `sample_valid_o` pulses one cycle after the eighth bit. `sample_is_q_o` is 0 for the first sample of a frame and then toggles from sample to sample.
- R6: `frame_end_o` pulses in the same cycle as the final sample's `sample_valid_o`, and that final sample is a Q sample.
- R7: A header with size code 6 or 7 gives a one-cycle `header_error_o` pulse, no `frame_start_o` and no samples. The hunt resumes with the next enabled bit.
- R8: After a frame ends, the hunt starts with empty history. Payload bits never form part of a sync match, even when the payload's tail together with the bits after it spells the sync word.
- R9: A cycle with `bit_en_i` low changes no state: `bit_i` is ignored, and no sample is produced in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial data bit |
| sample_valid_o | output | 1 | One-cycle strobe for a payload sample |
| sample_data_o | output | 8 | Payload sample, first received bit in bit 7 |
| sample_is_q_o | output | 1 | Sample is Q (1) or I (0) |
| frame_type_o | output | 4 | Channel type of the current frame |
| cts_o | output | 1 | Clear-to-send flag of the current frame |
| frame_start_o | output | 1 | Pulse after a header with a valid size code |
| frame_end_o | output | 1 | Pulse with the final sample of a frame |
| header_error_o | output | 1 | Pulse after a header with a reserved size code |

## Verification
The final-sample check assumes that every payload holds an even number of bytes. The size table guarantees this, and the stimulus uses only the default table. The single-cycle error-pulse property relies on at least eight enabled bits separating two rejected headers. That always holds, because a header can only follow a full sync word. The stimulus never applies an unknown value on `bit_i` while `bit_en_i` is high. It deliberately drives `bit_i` high during disabled cycles, so that bits which must be ignored carry a value that would matter if they were taken.

// File: rtl/iq_deframer_pkg.sv
`timescale 1ns/1ps
package iq_deframer_pkg;
  localparam int HDR_W  = 8;
  localparam int SIZE_W = 3;
  localparam int TYPE_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_PAY} dfr_state_e;
endpackage

// File: rtl/iq_sync_hunter.sv
`timescale 1ns/1ps
module iq_sync_hunter #(
  parameter int                SYNC_W    = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hA5F0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic clear_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int FILL_W = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] hist_q;
  logic [FILL_W-1:0] fill_q;

  // a match needs SYNC_W fresh bits since the last clear
  assign hit_o = shift_en_i && (fill_q >= FILL_W'(SYNC_W - 1)) &&
                 ({hist_q[SYNC_W-2:0], bit_i} == SYNC_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_en_i) begin
      hist_q <= {hist_q[SYNC_W-2:0], bit_i};
      if (fill_q != FILL_W'(SYNC_W)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/iq_hdr_decoder.sv
`timescale 1ns/1ps
module iq_hdr_decoder
  import iq_deframer_pkg::*;
#(
  parameter int                          CNT_W      = 10,
  parameter int                          NUM_SIZES  = 6,
  parameter logic [NUM_SIZES*CNT_W-1:0]  SIZE_TABLE = {10'd512, 10'd256, 10'd128,
                                                       10'd96, 10'd64, 10'd32}
) (
  input  logic [HDR_W-1:0]  hdr_i,
  output logic [TYPE_W-1:0] type_o,
  output logic              cts_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              reserved_o
);
  logic [SIZE_W-1:0] code;

  assign code       = hdr_i[HDR_W-1 -: SIZE_W];
  assign type_o     = hdr_i[TYPE_W:1];
  assign cts_o      = hdr_i[0];
  assign reserved_o = (int'(code) >= NUM_SIZES);

  always_comb begin
    limit_o = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (int'(code) == i) limit_o = SIZE_TABLE[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/iq_unpacker.sv
`timescale 1ns/1ps
module iq_unpacker
  import iq_deframer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic              last_o,
  output logic              sample_valid_o,
  output logic [BYTE_W-1:0] sample_data_o,
  output logic              sample_is_q_o
);
  localparam int LANE_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, lim_q;
  logic [BYTE_W-1:0] byte_q;
  logic              q_next_q;
  logic              byte_done;

  assign byte_done = en_i && (cnt_q[LANE_W-1:0] == LANE_W'(BYTE_W - 1));
  assign last_o    = en_i && (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q          <= '0;
      lim_q          <= '0;
      byte_q         <= '0;
      q_next_q       <= 1'b0;
      sample_valid_o <= 1'b0;
      sample_data_o  <= '0;
      sample_is_q_o  <= 1'b0;
    end else begin
      sample_valid_o <= 1'b0;
      if (start_i) begin
        cnt_q    <= '0;
        lim_q    <= limit_i;
        q_next_q <= 1'b0;
      end else if (en_i) begin
        byte_q <= {byte_q[BYTE_W-2:0], bit_i};
        cnt_q  <= cnt_q + 1'b1;
        if (byte_done) begin
          sample_valid_o <= 1'b1;
          sample_data_o  <= {byte_q[BYTE_W-2:0], bit_i};
          sample_is_q_o  <= q_next_q;
          q_next_q       <= ~q_next_q;
        end
      end
    end
  end

  AST_NO_BIT_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(en_i)); // R9
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < lim_q)); // R4
endmodule

// File: rtl/iq_deframer.sv
`timescale 1ns/1ps
module iq_deframer
  import iq_deframer_pkg::*;
#(
  parameter int                          SYNC_W     = 16,
  parameter logic [SYNC_W-1:0]           SYNC_WORD  = 16'hA5F0,
  parameter int                          CNT_W      = 10,
  parameter int                          NUM_SIZES  = 6,
  parameter logic [NUM_SIZES*CNT_W-1:0]  SIZE_TABLE = {10'd512, 10'd256, 10'd128,
                                                       10'd96, 10'd64, 10'd32}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  output logic              sample_valid_o,
  output logic [BYTE_W-1:0] sample_data_o,
  output logic              sample_is_q_o,
  output logic [TYPE_W-1:0] frame_type_o,
  output logic              cts_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              header_error_o
);
  localparam int HCNT_W = $clog2(HDR_W);

  dfr_state_e        state_q;
  logic [HDR_W-1:0]  hdr_q, hdr_full;
  logic [HCNT_W-1:0] hcnt_q;
  logic              hit, hdr_done, pay_last;
  logic [TYPE_W-1:0] dec_type;
  logic              dec_cts, dec_rsv;
  logic [CNT_W-1:0]  dec_limit;

  assign hdr_full = {hdr_q[HDR_W-2:0], bit_i};
  assign hdr_done = bit_en_i && (state_q == ST_HDR) && (hcnt_q == HCNT_W'(HDR_W - 1));

  iq_sync_hunter #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_hunt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (bit_en_i && (state_q == ST_HUNT)),
    .clear_i    (state_q != ST_HUNT),
    .bit_i      (bit_i),
    .hit_o      (hit)
  );

  iq_hdr_decoder #(.CNT_W(CNT_W), .NUM_SIZES(NUM_SIZES), .SIZE_TABLE(SIZE_TABLE)) u_dec (
    .hdr_i      (hdr_full),
    .type_o     (dec_type),
    .cts_o      (dec_cts),
    .limit_o    (dec_limit),
    .reserved_o (dec_rsv)
  );

  iq_unpacker #(.CNT_W(CNT_W)) u_unpk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (hdr_done && !dec_rsv),
    .limit_i        (dec_limit),
    .en_i           (bit_en_i && (state_q == ST_PAY)),
    .bit_i          (bit_i),
    .last_o         (pay_last),
    .sample_valid_o (sample_valid_o),
    .sample_data_o  (sample_data_o),
    .sample_is_q_o  (sample_is_q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_HUNT;
      hdr_q          <= '0;
      hcnt_q         <= '0;
      frame_type_o   <= '0;
      cts_o          <= 1'b0;
      frame_start_o  <= 1'b0;
      frame_end_o    <= 1'b0;
      header_error_o <= 1'b0;
    end else begin
      frame_start_o  <= 1'b0;
      frame_end_o    <= 1'b0;
      header_error_o <= 1'b0;
      if (bit_en_i) begin
        unique case (state_q)
          ST_HUNT: if (hit) begin
            state_q <= ST_HDR;
            hcnt_q  <= '0;
          end
          ST_HDR: begin
            hdr_q  <= hdr_full;
            hcnt_q <= hcnt_q + 1'b1;
            if (hdr_done) begin
              if (dec_rsv) begin
                header_error_o <= 1'b1;
                state_q        <= ST_HUNT;
              end else begin
                frame_start_o <= 1'b1;
                frame_type_o  <= dec_type;
                cts_o         <= dec_cts;
                state_q       <= ST_PAY;
              end
            end
          end
          ST_PAY: if (pay_last) begin
            frame_end_o <= 1'b1;
            state_q     <= ST_HUNT;
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  AST_END_WITH_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> sample_valid_o); // R6
  AST_LAST_IS_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> sample_is_q_o); // R6
  AST_START_INTO_PAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (state_q == ST_PAY)); // R3
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    header_error_o |=> !header_error_o); // R7
  AST_ERR_BACK_TO_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    header_error_o |-> (state_q == ST_HUNT) && !frame_start_o); // R7
endmodule

// File: tb/iq_deframer_tb.sv
`timescale 1ns/1ps
module iq_deframer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       sv, sq, cts, fs, fe, he;
  logic [7:0] sdata;
  logic [3:0] ftype;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iq_deframer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_in),
    .sample_valid_o(sv), .sample_data_o(sdata), .sample_is_q_o(sq),
    .frame_type_o(ftype), .cts_o(cts), .frame_start_o(fs),
    .frame_end_o(fe), .header_error_o(he)
  );

  // monitor
  logic [7:0] mon_data [1024];
  logic       mon_q    [1024];
  logic [3:0] mon_type [1024];
  logic       mon_cts  [1024];
  int n_samp = 0, n_start = 0, n_end = 0, n_err = 0, end_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (sv && n_samp < 1024) begin
      mon_data[n_samp] = sdata; mon_q[n_samp] = sq;
      mon_type[n_samp] = ftype; mon_cts[n_samp] = cts;
      n_samp++;
    end
    if (fs) n_start++;
    if (he) n_err++;
    if (fe) begin n_end++; if (!(sv && sq)) end_bad++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int nb = 0;
  task automatic drive(input logic b, input logic e);
    @(negedge clk); bit_in = b; bit_en = e;
  endtask
  task automatic send_bit(input logic b, input int stall);
    drive(b, 1'b1); nb++;
    if (stall != 0 && nb % stall == 0) drive(1'b1, 1'b0); // ignored bit, R9
  endtask
  task automatic send_byte(input logic [7:0] v, input int stall);
    for (int i = 7; i >= 0; i--) send_bit(v[i], stall);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0);
  endtask

  function automatic int exp_bits(input int code);
    case (code)
      0: return 32;  1: return 64;  2: return 96;
      3: return 128; 4: return 256; 5: return 512;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] pay_byte(input int seed, input int n);
    return 8'((seed + n * 29) & 8'hFF);
  endfunction

  task automatic send_frame(input int gap, input int code, input logic [3:0] typ,
                            input logic c, input int stall, input int seed, input bit tail_a5);
    int nbytes;
    logic [7:0] b;
    nbytes = exp_bits(code) / 8;
    for (int i = 0; i < gap; i++) send_bit(1'b0, stall);
    send_byte(8'hA5, stall); send_byte(8'hF0, stall);
    send_byte({3'(code), typ, c}, stall);
    for (int n = 0; n < nbytes; n++) begin
      b = (tail_a5 && n == nbytes - 1) ? 8'hA5 : pay_byte(seed, n);
      send_byte(b, stall);
    end
  endtask

  task automatic check_frame(input int base, input int nbytes, input int seed,
                             input logic [3:0] typ, input logic c, input bit tail_a5);
    logic [7:0] e;
    chk(n_samp - base == nbytes, "R4 sample count", n_samp - base, nbytes);
    for (int n = 0; n < nbytes && base + n < 1024; n++) begin
      e = (tail_a5 && n == nbytes - 1) ? 8'hA5 : pay_byte(seed, n);
      chk(mon_data[base+n] == e, "R5 sample data", mon_data[base+n], e);
      chk(mon_q[base+n] == 1'(n % 2), "R5 I/Q order", mon_q[base+n], n % 2);
      chk(mon_type[base+n] == typ, "R3 type tag", mon_type[base+n], typ);
      chk(mon_cts[base+n] == c, "R3 cts flag", mon_cts[base+n], c);
    end
  endtask

  // {gap[7:0], code[2:0], type[3:0], cts, stall[3:0]}
  localparam logic [19:0] VEC [6] = '{
    {8'd3,  3'd0, 4'h1, 1'b1, 4'd0},
    {8'd0,  3'd1, 4'hC, 1'b0, 4'd3},
    {8'd11, 3'd2, 4'h2, 1'b1, 4'd0},
    {8'd1,  3'd3, 4'hE, 1'b0, 4'd5},
    {8'd7,  3'd4, 4'h7, 1'b1, 4'd0},
    {8'd2,  3'd5, 4'h9, 1'b0, 4'd7}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int bs, b0, e0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(!sv && !fs && !fe && !he, "R1 pulses low after reset", {sv, fs, fe, he}, 0);

    // table-driven frames: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      bs = n_samp; b0 = n_start; e0 = n_end;
      nb = 0;
      send_frame(int'(VEC[v][19:12]), int'(VEC[v][11:9]), VEC[v][8:5], VEC[v][4],
                 int'(VEC[v][3:0]), v * 53 + 11, 1'b0);
      idle(3);
      chk(n_start - b0 == 1, "R2 frame detected", n_start - b0, 1);
      chk(n_end - e0 == 1, "R6 one frame end", n_end - e0, 1);
      check_frame(bs, exp_bits(int'(VEC[v][11:9])) / 8, v * 53 + 11,
                  VEC[v][8:5], VEC[v][4], 1'b0);
    end

    // R7 reserved size codes, hunt resumes on the next bit
    for (int rc = 6; rc < 8; rc++) begin
      b0 = n_start; r0 = n_err; bs = n_samp; nb = 0;
      send_byte(8'hA5, 0); send_byte(8'hF0, 0);
      send_byte({3'(rc), 4'h3, 1'b0}, 0);
      idle(2);
      chk(n_err - r0 == 1, "R7 header_error pulse", n_err - r0, 1);
      chk(n_start - b0 == 0 && n_samp == bs, "R7 no frame on reserved", n_start - b0, 0);
      send_frame(0, 0, 4'h4, 1'b1, 0, 99 + rc, 1'b0);
      idle(3);
      chk(n_start - b0 == 1, "R7 hunt resumes", n_start - b0, 1);
      check_frame(bs, 4, 99 + rc, 4'h4, 1'b1, 1'b0);
    end

    // R8 payload tail plus following bits spell the sync word
    b0 = n_start; r0 = n_err; bs = n_samp; nb = 0;
    send_frame(2, 0, 4'h5, 1'b1, 0, 7, 1'b1);
    send_byte(8'hF0, 0); send_byte(8'h20, 0);
    for (int i = 0; i < 8; i++) send_byte(8'h00, 0);
    idle(3);
    chk(n_start - b0 == 1, "R8 no overlap sync", n_start - b0, 1);
    chk(n_err - r0 == 0, "R8 no spurious header", n_err - r0, 0);
    check_frame(bs, 4, 7, 4'h5, 1'b1, 1'b1);

    // R2 near miss, then sync at an odd bit offset
    b0 = n_start; bs = n_samp; nb = 0;
    send_byte(8'hA5, 0); send_byte(8'hF1, 0);
    send_bit(1'b1, 0); send_bit(1'b1, 0); send_bit(1'b1, 0);
    idle(2);
    chk(n_start - b0 == 0, "R2 near miss rejected", n_start - b0, 0);
    send_frame(0, 1, 4'hA, 1'b0, 0, 200, 1'b0);
    idle(3);
    chk(n_start - b0 == 1, "R2 sync at odd offset", n_start - b0, 1);
    check_frame(bs, 8, 200, 4'hA, 1'b0, 1'b0);

    // R9 disabled cycles during hunt leave nothing behind
    chk(!sv && !fs && !fe && !he, "R9 idle outputs quiet", {sv, fs, fe, he}, 0);
    chk(end_bad == 0, "R6 end aligned with last Q sample", end_bad, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule